// File: doc/BRIEF.md
# Probe Trigger Match Unit

This block watches one probe bus inside an on-chip logic analyzer and raises a single-bit match flag whenever the probe satisfies a condition that software has programmed. The condition can be a per-bit pattern or a whole-word magnitude compare. A per-bit pattern mixes fixed levels, ignored bits and transitions between the current sample and the one before it. Magnitude compares treat the probe as an unsigned number and test it against a programmed compare value.

Configuration is written at runtime through three small write strobes: one loads the operator, one loads the compare value, and one loads the 3-bit code of a single probe bit. The probe can pass through zero to six register stages before it reaches the comparator, so the unit can be placed far from the logic it observes. The match flag is registered. Several such units would normally feed a trigger combiner, which lies outside this block.

Top module: `probe_match_unit`

## Requirements
- R1: The probe sample used for a decision has passed through exactly PIPE_STAGES registers, and the match flag adds one more register. A probe value present before clock edge k therefore decides the match flag that is visible after edge k+PIPE_STAGES.
- R2: While rst_n is low, match_out is 0. Reset sets the operator to 0, the compare value to 0 and every per-bit code to 0.
- R3: match_out stays 0 until a real probe sample has come out of the input pipeline. After reset is released, the flags following the first PIPE_STAGES edges are 0 whatever the configuration.
- R4: Operator 0 (pattern equal) matches when every bit satisfies its 3-bit code. The level codes are: 0 = bit ignored, 1 = bit must be 0, 2 = bit must be 1.
- R5: The edge codes compare a bit's current sample with its previous sample: 3 = rise, 4 = fall, 5 = either change, 6 = no change. On the first valid sample after reset there is no previous sample, so any bit with an edge code fails. Code 7 never holds.
- R6: Operator 1 (pattern not-equal) matches exactly when operator 0 would not match for the same sample.
- R7: Operators 2, 3, 4 and 5 test the unsigned probe against the compare value for greater-than, less-than, greater-or-equal and less-or-equal. These operators ignore the per-bit codes.
- R8: Operators 6 and 7 never produce a match.
- R9: A configuration write takes effect for the decision formed in the following cycle. A code write changes only the addressed bit, and a write whose index is at or above PROBE_W is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the observed logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_in | input | PROBE_W | Probe bus being watched |
| op_we | input | 1 | Load strobe for the operator |
| op_in | input | 3 | Operator code (0 eq, 1 neq, 2 gt, 3 lt, 4 ge, 5 le) |
| val_we | input | 1 | Load strobe for the compare value |
| val_in | input | PROBE_W | Compare value for magnitude operators |
| code_we | input | 1 | Load strobe for one per-bit code |
| code_idx | input | IDX_W | Probe bit addressed by the code write |
| code_in | input | 3 | Per-bit code value |
| match_out | output | 1 | Registered match flag |

## Verification
On every cycle, assertions check the pipeline delay of the probe and the silence of the flag before the first valid sample. They also check that the reserved operators never match, that edge codes are suppressed before a previous sample exists, and the bounds of the greater-than and greater-or-equal results. Only the bench scenarios show the full truth table of each per-bit code over every transition of a bit, and that not-equal is the exact complement of equal over all probe values. The same holds for the magnitude operators across the whole unsigned range with stray codes left programmed, for the isolation of single-bit code writes, and for the first-sample edge suppression right after reset.

// File: rtl/probe_match_unit.sv
module probe_match_unit #(
  parameter int PROBE_W     = 8,
  parameter int PIPE_STAGES = 2,
  localparam int IDX_W      = (PROBE_W > 1) ? $clog2(PROBE_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_in,
  input  logic               op_we,
  input  logic [2:0]         op_in,
  input  logic               val_we,
  input  logic [PROBE_W-1:0] val_in,
  input  logic               code_we,
  input  logic [IDX_W-1:0]   code_idx,
  input  logic [2:0]         code_in,
  output logic               match_out
);

  logic [PROBE_W-1:0] cur, prev_q, val_q, bit_ok;
  logic               cur_vld, prev_vld, hit;
  logic [2:0]         op_q;
  logic [2:0]         code_q [PROBE_W];

  function automatic logic bit_eval(input logic [2:0] c, input logic now, input logic was,
                                    input logic pv);
    case (c)
      3'd0:    bit_eval = 1'b1;
      3'd1:    bit_eval = !now;
      3'd2:    bit_eval = now;
      3'd3:    bit_eval = pv && !was && now;
      3'd4:    bit_eval = pv && was && !now;
      3'd5:    bit_eval = pv && (was != now);
      3'd6:    bit_eval = pv && (was == now);
      default: bit_eval = 1'b0;
    endcase
  endfunction

  generate
    if (PIPE_STAGES == 0) begin : g_nopipe
      assign cur     = probe_in;
      assign cur_vld = 1'b1;
    end else begin : g_pipe
      logic [PROBE_W-1:0]     stg [PIPE_STAGES];
      logic [PIPE_STAGES-1:0] vld;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < PIPE_STAGES; i++) stg[i] <= '0;
          vld <= '0;
        end else begin
          stg[0] <= probe_in;
          vld[0] <= 1'b1;
          for (int i = 1; i < PIPE_STAGES; i++) begin
            stg[i] <= stg[i-1];
            vld[i] <= vld[i-1];
          end
        end
      end

      assign cur     = stg[PIPE_STAGES-1];
      assign cur_vld = vld[PIPE_STAGES-1];

      // R1
      pipe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_vld |-> cur == $past(probe_in, PIPE_STAGES));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= 3'd0;
      val_q <= '0;
      for (int i = 0; i < PROBE_W; i++) code_q[i] <= 3'd0;
    end else begin
      if (op_we)  op_q  <= op_in;
      if (val_we) val_q <= val_in;
      if (code_we && int'(code_idx) < PROBE_W) code_q[code_idx] <= code_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      prev_vld <= 1'b0;
    end else begin
      prev_q   <= cur;
      prev_vld <= cur_vld;
    end
  end

  for (genvar gi = 0; gi < PROBE_W; gi++) begin : g_bit
    assign bit_ok[gi] = bit_eval(code_q[gi], cur[gi], prev_q[gi], prev_vld);

    // R5
    edge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!prev_vld && op_q == 3'd0 && code_q[gi] >= 3'd3) |=> !match_out);
  end

  always_comb begin
    case (op_q)
      3'd0:    hit = &bit_ok;
      3'd1:    hit = ~&bit_ok;
      3'd2:    hit = cur >  val_q;
      3'd3:    hit = cur <  val_q;
      3'd4:    hit = cur >= val_q;
      3'd5:    hit = cur <= val_q;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_out <= 1'b0;
    else        match_out <= cur_vld && hit;
  end

  // R3
  early_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_vld |=> !match_out);

  // R8
  reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q > 3'd5) |=> !match_out);

  // R7
  gt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 3'd2 && cur <= val_q) |=> !match_out);

  // R7
  ge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vld && op_q == 3'd4 && cur >= val_q) |=> match_out);

endmodule

// File: tb/probe_match_unit_tb_top.sv
module probe_match_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int S = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] probe_in = '0;
  logic         op_we = 1'b0, val_we = 1'b0, code_we = 1'b0;
  logic [2:0]   op_in = '0, code_in = '0;
  logic [W-1:0] val_in = '0;
  logic [1:0]   code_idx = '0;
  logic         match_out;

  int n_checks = 0, n_fail = 0, edge_n = 0;
  logic [W-1:0] hist [0:16383];
  logic [2:0]   m_op;
  logic [W-1:0] m_val;
  logic [2:0]   m_code [W];

  always #(CLK_PERIOD/2) clk = ~clk;

  probe_match_unit #(.PROBE_W(W), .PIPE_STAGES(S)) dut_i (
    .clk(clk), .rst_n(rst_n), .probe_in(probe_in), .op_we(op_we), .op_in(op_in),
    .val_we(val_we), .val_in(val_in), .code_we(code_we), .code_idx(code_idx),
    .code_in(code_in), .match_out(match_out));

  function automatic logic bit_model(input logic [2:0] c, input logic now, input logic was,
                                     input logic pv);
    case (c)
      3'd0: return 1'b1;
      3'd1: return now == 1'b0;
      3'd2: return now == 1'b1;
      3'd3: return pv && was == 1'b0 && now == 1'b1;
      3'd4: return pv && was == 1'b1 && now == 1'b0;
      3'd5: return pv && was != now;
      3'd6: return pv && was == now;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic model(input int n);
    logic [W-1:0] c, p;
    logic pv, all;
    if (n - S < 1) return 1'b0;
    c  = hist[n-S];
    pv = (n - S - 1) >= 1;
    p  = pv ? hist[n-S-1] : '0;
    all = 1'b1;
    for (int b = 0; b < W; b++) all = all && bit_model(m_code[b], c[b], p[b], pv);
    case (m_op)
      3'd0: return all;
      3'd1: return !all;
      3'd2: return int'(c) >  int'(m_val);
      3'd3: return int'(c) <  int'(m_val);
      3'd4: return int'(c) >= int'(m_val);
      3'd5: return int'(c) <= int'(m_val);
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s edge %0d: match_out=%0b expected %0b", tag, edge_n, act, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] p, input string tag);
    probe_in = p;
    @(posedge clk);
    edge_n++;
    hist[edge_n] = p;
    @(negedge clk);
    check(tag, match_out, model(edge_n));
  endtask

  task automatic cfg_edge();
    @(posedge clk);
    edge_n++;
    hist[edge_n] = probe_in;
    @(negedge clk);
    op_we = 1'b0; val_we = 1'b0; code_we = 1'b0;
  endtask

  task automatic wr_op(input logic [2:0] o);
    op_in = o; op_we = 1'b1; cfg_edge(); m_op = o;
  endtask

  task automatic wr_val(input logic [W-1:0] v);
    val_in = v; val_we = 1'b1; cfg_edge(); m_val = v;
  endtask

  task automatic wr_code(input int idx, input logic [2:0] c);
    code_idx = 2'(idx); code_in = c; code_we = 1'b1; cfg_edge(); m_code[idx] = c;
  endtask

  task automatic clear_codes();
    for (int b = 0; b < W; b++) wr_code(b, 3'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 reset", match_out, 1'b0);
    end
    m_op = 3'd0; m_val = '0;
    for (int b = 0; b < W; b++) m_code[b] = 3'd0;
    edge_n = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    // R3: flag held low until the pipeline delivers a sample, then eq with all ignored matches
    for (int k = 0; k < 6; k++) step(W'(k), k < S ? "R3 pipeline fill" : "R2 reset config");

    // R1: single-cycle pulse appears exactly S+1 edges later
    wr_code(0, 3'd2); wr_code(1, 3'd1); wr_code(2, 3'd1); wr_code(3, 3'd1);
    for (int k = 0; k < 8; k++) step(k == 2 ? 4'b0001 : 4'b0000, "R1 latency");
    clear_codes();

    // R4: each level code on each bit, all probe values
    for (int b = 0; b < W; b++) begin
      for (int c = 1; c <= 2; c++) begin
        wr_code(b, 3'(c));
        for (int v = 0; v < 16; v++) step(W'(v), "R4 level code");
        wr_code(b, 3'd0);
      end
    end
    // R4: mixed pattern 1x01
    wr_code(3, 3'd2); wr_code(1, 3'd1); wr_code(0, 3'd2);
    for (int v = 0; v < 16; v++) step(W'(v), "R4 pattern");
    // R6: complement of the same pattern
    wr_op(3'd1);
    for (int v = 0; v < 16; v++) step(W'(v), "R6 not-equal");
    wr_op(3'd0);
    clear_codes();

    // R5: each edge code over every pair of consecutive samples
    for (int c = 3; c <= 7; c++) begin
      wr_code(1, 3'(c));
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          step(W'(a), "R5 edge code");
          step(W'(b), "R5 edge code");
        end
      wr_code(1, 3'd0);
    end
    wr_op(3'd1); wr_code(2, 3'd5);
    for (int v = 0; v < 16; v++) step(W'(v ^ (v >> 1)), "R6 not-equal edge");
    wr_op(3'd0); clear_codes();

    // R9: writing another bit leaves bit 0 code intact; out-of-range index unused (W is a power of two)
    wr_code(0, 3'd2);
    wr_code(3, 3'd1);
    for (int v = 0; v < 16; v++) step(W'(v), "R9 code isolation");

    // R7: magnitude operators ignore per-bit codes still programmed
    wr_code(2, 3'd3);
    for (int o = 2; o <= 5; o++) begin
      wr_op(3'(o));
      for (int vi = 0; vi < 4; vi++) begin
        wr_val(vi == 0 ? 4'd0 : vi == 1 ? 4'd5 : vi == 2 ? 4'd10 : 4'd15);
        for (int v = 0; v < 16; v++) step(W'(v), "R7 magnitude");
      end
    end

    // R8: reserved operators
    for (int o = 6; o <= 7; o++) begin
      wr_op(3'(o));
      for (int v = 0; v < 16; v++) step(W'(v), "R8 reserved op");
    end

    // R5: first valid sample after reset cannot satisfy an edge code
    do_reset();
    probe_in = 4'b0001;
    wr_code(0, 3'd5);
    for (int k = 0; k < 6; k++) step(k < 2 ? 4'b0000 : 4'b0001, "R5 first sample");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule